// File: doc/BRIEF.md
# Three-Phase Gate Command Interlock

This block sits between a PWM controller and the gate drivers of a three-leg inverter bridge. It takes six active-low switch commands, one upper (high-side) and one lower (low-side) per leg, and turns them into six active-high gate enables. Each command and the global enable are first brought into the clock domain. Each then passes through a pulse-width filter, so glitches shorter than the filter time never reach a gate.

Each leg has its own interlock. It never lets both switches of the leg conduct, and it keeps both off for a fixed dead time before either one turns on. A global enable, a fault trip flag, a low-side undervoltage flag and per-leg high-side undervoltage flags all force outputs off. Low-side gates resume from the command level when their undervoltage flag clears. A high-side gate stays off after its supply dropout until its command shows a new turn-on edge. All timing is in clock cycles and is set by parameters.

Top module: `gd_interlock3`

## Requirements
- R1: A command input at logic 0 requests its switch on and logic 1 requests it off. In steady state each gate output follows the inverse of its command, subject to the rules below. Bit i of every 3-bit vector belongs to leg i.
- R2: A change on a command input reaches its gate output on the (FILT_CYC+3)th rising clock edge after the change. This assumes the leg is idle with its dead time elapsed, or is the switch already on.
- R3: A command pulse held for fewer than FILT_CYC clock cycles never reaches the gate output.
- R4: Within a leg, `hs_gate[i]` and `ls_gate[i]` are never both 1.
- R5: When one switch of a leg turns off and the other switch is requested, the other switch turns on exactly DEAD_CYC clock cycles after the first one goes off. Both stay off for the whole of that interval.
- R6: While one switch of a leg is on, a request for the other switch of that leg is ignored. Once the on switch's command is released, the waiting switch turns on after the dead time.
- R7: If both commands of a leg are wanted while the leg is idle and its dead time has elapsed, neither gate turns on. When one request is withdrawn, the remaining one is served.
- R8: When `enable` is low, all six gates go off. `enable` has its own FILT_CYC filter, so a low pulse shorter than FILT_CYC cycles leaves the gates unchanged.
- R9: While `trip` is high, all six gates are off; they go off on the third rising edge after `trip` rises.
- R10: While `ls_uv` is high, all low-side gates are off. When it clears, each low-side gate again follows its command level without needing a new edge.
- R11: While `hs_uv[i]` is high, `hs_gate[i]` is off. After the flag clears, `hs_gate[i]` stays off, even with its command still held on, until that command goes off and then on again.
- R12: During reset and on the first cycle after it, all gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_cmd_n | input | 3 | Active-low high-side switch commands, one per leg |
| ls_cmd_n | input | 3 | Active-low low-side switch commands, one per leg |
| enable | input | 1 | Global enable, active high, filtered |
| trip | input | 1 | Fault shutdown flag, active high |
| ls_uv | input | 1 | Low-side supply undervoltage flag |
| hs_uv | input | 3 | Per-leg high-side supply undervoltage flags |
| hs_gate | output | 3 | High-side gate enables, active high |
| ls_gate | output | 3 | Low-side gate enables, active high |

## Verification
The hardest states to reach from the ports are the interlock races. Both requests of a leg must become valid on the same edge, and a request must arrive while the opposite switch is already on. The stimulus drives the two commands of a leg on the same falling edge, so their synchronizers and filters move in lockstep. To test the ignore rule, it turns one switch fully on before asserting the opposite command. The high-side re-arm rule is reached by holding a command active across a whole undervoltage episode, then checking that the gate stays off until the command is toggled.

// File: rtl/gd_pkg.sv
package gd_pkg;
  typedef enum logic [1:0] {
    LEG_IDLE = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_state_e;
endpackage

// File: rtl/gd_sync.sv
module gd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gd_filter.sv
module gd_filter #(
  parameter int CYC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic y
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      y   <= 1'b0;
      cnt <= '0;
    end else if (x == y) begin
      cnt <= '0;
    end else if (cnt == CW'(CYC - 1)) begin
      y   <= x;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gd_leg.sv
module gd_leg
  import gd_pkg::*;
#(
  parameter int DEAD_CYC = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic hreq,
  input  logic lreq,
  input  logic hs_blk,
  input  logic ls_blk,
  input  logic hs_uv,
  output logic hs_on,
  output logic ls_on
);
  localparam int DW = $clog2(DEAD_CYC + 1);

  leg_state_e    state;
  logic [DW-1:0] dcnt;
  logic          hreq_d, armed;
  logic          hrise, arm_now, h_want, l_want;

  // a high-side request counts only if it began after the last dropout
  assign hrise   = hreq & ~hreq_d;
  assign arm_now = hreq & (armed | hrise) & ~hs_uv;
  assign h_want  = arm_now & ~hs_blk;
  assign l_want  = lreq & ~ls_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      hreq_d <= 1'b0;
      armed  <= 1'b0;
    end else begin
      hreq_d <= hreq;
      armed  <= arm_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LEG_IDLE;
      dcnt  <= '0;
    end else begin
      case (state)
        LEG_HIGH: if (!h_want) begin
          state <= LEG_IDLE;
          dcnt  <= DW'(DEAD_CYC - 1);
        end
        LEG_LOW: if (!l_want) begin
          state <= LEG_IDLE;
          dcnt  <= DW'(DEAD_CYC - 1);
        end
        default: begin
          if (dcnt != '0)           dcnt  <= dcnt - 1'b1;
          else if (h_want && !l_want) state <= LEG_HIGH;
          else if (l_want && !h_want) state <= LEG_LOW;
        end
      endcase
    end
  end

  assign hs_on = (state == LEG_HIGH);
  assign ls_on = (state == LEG_LOW);
endmodule

// File: rtl/gd_interlock3.sv
module gd_interlock3 #(
  parameter int LEGS        = 3,
  parameter int FILT_CYC    = 30,
  parameter int DEAD_CYC    = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LEGS-1:0] hs_cmd_n,
  input  logic [LEGS-1:0] ls_cmd_n,
  input  logic            enable,
  input  logic            trip,
  input  logic            ls_uv,
  input  logic [LEGS-1:0] hs_uv,
  output logic [LEGS-1:0] hs_gate,
  output logic [LEGS-1:0] ls_gate
);
  // synchronizer bit layout: commands, enable, trip, ls_uv, hs_uv
  localparam int NCMD = 2 * LEGS;
  localparam int NSYN = NCMD + 3 + LEGS;
  localparam logic [NSYN-1:0] SYN_RST = {{(LEGS + 3){1'b0}}, {NCMD{1'b1}}};

  logic [NSYN-1:0] raw, syn;
  logic [NCMD:0]   filt_in, filt_out;
  logic            en_f, trip_s, ls_uv_s;
  logic [LEGS-1:0] hs_uv_s;

  assign raw = {hs_uv, ls_uv, trip, enable, ls_cmd_n, hs_cmd_n};

  gd_sync #(.W(NSYN), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  // commands inverted to active-high requests, enable passed straight
  assign filt_in = {syn[NCMD], ~syn[NCMD-1:0]};
  assign trip_s  = syn[NCMD+1];
  assign ls_uv_s = syn[NCMD+2];
  assign hs_uv_s = syn[NSYN-1:NCMD+3];

  generate
    for (genvar f = 0; f <= NCMD; f++) begin : g_filt
      gd_filter #(.CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst(rst), .x(filt_in[f]), .y(filt_out[f])
      );
    end
  endgenerate

  assign en_f = filt_out[NCMD];

  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      gd_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
        .clk(clk), .rst(rst),
        .hreq(filt_out[g]), .lreq(filt_out[LEGS+g]),
        .hs_blk(~en_f | trip_s | hs_uv_s[g]),
        .ls_blk(~en_f | trip_s | ls_uv_s),
        .hs_uv(hs_uv_s[g]),
        .hs_on(hs_gate[g]), .ls_on(ls_gate[g])
      );
    end
  endgenerate
endmodule

// File: rtl/gd_interlock3_chk.sv
module gd_interlock3_chk #(
  parameter int LEGS = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            trip,
  input logic [LEGS-1:0] hs_uv,
  input logic [LEGS-1:0] hs_gate,
  input logic [LEGS-1:0] ls_gate
);
  // R4
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_gate & ls_gate) == '0);

  // R9
  trip_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(trip, 3) && $past(trip, 2) && $past(trip, 1)) |-> (hs_gate == '0 && ls_gate == '0));

  // R12
  reset_off_chk: assert property (@(posedge clk)
    $past(rst) |-> (hs_gate == '0 && ls_gate == '0));

  generate
    for (genvar i = 0; i < LEGS; i++) begin : g_leg_chk
      // R5
      dead_lo_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_gate[i]) |-> (!$past(hs_gate[i]) && !$past(hs_gate[i], 2)));
      // R5
      dead_hi_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate[i]) |-> (!$past(ls_gate[i]) && !$past(ls_gate[i], 2)));
      // R11
      hs_uv_off_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hs_uv[i], 3) && $past(hs_uv[i], 2) && $past(hs_uv[i], 1)) |-> !hs_gate[i]);
    end
  endgenerate
endmodule

bind gd_interlock3 gd_interlock3_chk #(.LEGS(LEGS)) u_chk (
  .clk(clk), .rst(rst), .trip(trip), .hs_uv(hs_uv),
  .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/gd_interlock3_tb.sv
module gd_interlock3_tb;
  localparam int FILT = 4;
  localparam int DEAD = 5;
  localparam int SETTLE = 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hs_cmd_n = 3'b111;
  logic [2:0] ls_cmd_n = 3'b111;
  logic       enable = 1'b1;
  logic       trip = 1'b0;
  logic       ls_uv = 1'b0;
  logic [2:0] hs_uv = 3'b000;
  logic [2:0] hs_gate, ls_gate;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  gd_interlock3 #(.LEGS(3), .FILT_CYC(FILT), .DEAD_CYC(DEAD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .hs_cmd_n(hs_cmd_n), .ls_cmd_n(ls_cmd_n),
    .enable(enable), .trip(trip), .ls_uv(ls_uv), .hs_uv(hs_uv),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  // steady-state vectors: {hs_cmd_n, ls_cmd_n, expected hs_gate, expected ls_gate}
  localparam logic [11:0] VEC [6] = '{
    {3'b110, 3'b111, 3'b001, 3'b000},
    {3'b111, 3'b101, 3'b000, 3'b010},
    {3'b011, 3'b110, 3'b100, 3'b001},
    {3'b111, 3'b111, 3'b000, 3'b000},
    {3'b010, 3'b101, 3'b101, 3'b010},
    {3'b111, 3'b000, 3'b000, 3'b111}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got hs/ls=%b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_all();
    hs_cmd_n = 3'b111;
    ls_cmd_n = 3'b111;
    tick(SETTLE);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    logic seen;
    // R12: outputs off in reset and just after, even with a command held
    hs_cmd_n = 3'b110;
    tick(5);
    chk("R12 in reset", {hs_gate, ls_gate}, 6'b0);
    rst = 1'b0;
    tick(1);
    chk("R12 after reset", {hs_gate, ls_gate}, 6'b0);
    idle_all();

    // R1: table walk
    for (int v = 0; v < 6; v++) begin
      hs_cmd_n = VEC[v][11:9];
      ls_cmd_n = VEC[v][8:6];
      tick(SETTLE);
      chk("R1 vector", {hs_gate, ls_gate}, VEC[v][5:0]);
    end
    idle_all();

    // R2: exact latency
    ls_cmd_n = 3'b110;
    tick(FILT + 2);
    chk("R2 before", {hs_gate, ls_gate}, 6'b000_000);
    tick(1);
    chk("R2 at edge", {hs_gate, ls_gate}, 6'b000_001);
    idle_all();

    // R3: short pulse suppressed, longer pulse passes
    seen = 1'b0;
    ls_cmd_n = 3'b101;
    tick(FILT - 1);
    ls_cmd_n = 3'b111;
    for (int k = 0; k < 20; k++) begin
      tick(1);
      if (ls_gate[1]) seen = 1'b1;
    end
    chk("R3 short pulse", {5'b0, seen}, 6'b0);
    seen = 1'b0;
    ls_cmd_n = 3'b101;
    tick(FILT + 1);
    ls_cmd_n = 3'b111;
    for (int k = 0; k < 20; k++) begin
      tick(1);
      if (ls_gate[1]) seen = 1'b1;
    end
    chk("R3 long pulse", {5'b0, seen}, 6'b1);
    idle_all();

    // R5: dead time count on a direct hand-over in leg 0
    hs_cmd_n = 3'b110;
    tick(SETTLE);
    hs_cmd_n = 3'b111;
    ls_cmd_n = 3'b110;
    cnt = 0;
    while (hs_gate[0]) tick(1);
    while (!ls_gate[0] && cnt < 50) begin
      tick(1);
      cnt++;
    end
    chk("R5 dead cycles", 6'(cnt), 6'(DEAD));
    idle_all();

    // R6: low side on, later high request ignored, then served
    ls_cmd_n = 3'b110;
    tick(SETTLE);
    hs_cmd_n = 3'b110;
    tick(SETTLE);
    chk("R6 ignored", {hs_gate, ls_gate}, 6'b000_001);
    ls_cmd_n = 3'b111;
    tick(SETTLE);
    chk("R6 served", {hs_gate, ls_gate}, 6'b001_000);
    idle_all();

    // R7: both requests together in leg 1
    hs_cmd_n = 3'b101;
    ls_cmd_n = 3'b101;
    tick(SETTLE);
    chk("R7 both", {hs_gate, ls_gate}, 6'b000_000);
    ls_cmd_n = 3'b111;
    tick(SETTLE);
    chk("R7 one left", {hs_gate, ls_gate}, 6'b010_000);
    idle_all();

    // R8: enable glitch ignored, long low forces off
    hs_cmd_n = 3'b110;
    ls_cmd_n = 3'b101;
    tick(SETTLE);
    enable = 1'b0;
    tick(FILT - 1);
    enable = 1'b1;
    tick(SETTLE);
    chk("R8 glitch", {hs_gate, ls_gate}, 6'b001_010);
    enable = 1'b0;
    tick(SETTLE);
    chk("R8 disabled", {hs_gate, ls_gate}, 6'b000_000);
    enable = 1'b1;
    tick(SETTLE);
    chk("R8 enabled", {hs_gate, ls_gate}, 6'b001_010);

    // R9: trip off on third edge
    trip = 1'b1;
    tick(2);
    chk("R9 not yet", {hs_gate, ls_gate}, 6'b001_010);
    tick(1);
    chk("R9 off", {hs_gate, ls_gate}, 6'b000_000);
    trip = 1'b0;
    tick(SETTLE);
    chk("R9 release", {hs_gate, ls_gate}, 6'b001_010);
    idle_all();

    // R10: low-side undervoltage, resumes on level
    ls_cmd_n = 3'b110;
    tick(SETTLE);
    ls_uv = 1'b1;
    tick(SETTLE);
    chk("R10 uv", {hs_gate, ls_gate}, 6'b000_000);
    ls_uv = 1'b0;
    tick(SETTLE);
    chk("R10 resume", {hs_gate, ls_gate}, 6'b000_001);
    idle_all();

    // R11: high-side dropout on leg 2 needs a new edge
    hs_cmd_n = 3'b011;
    tick(SETTLE);
    chk("R11 on", {hs_gate, ls_gate}, 6'b100_000);
    hs_uv = 3'b100;
    tick(SETTLE);
    chk("R11 uv", {hs_gate, ls_gate}, 6'b000_000);
    hs_uv = 3'b000;
    tick(SETTLE);
    chk("R11 held", {hs_gate, ls_gate}, 6'b000_000);
    hs_cmd_n = 3'b111;
    tick(SETTLE);
    hs_cmd_n = 3'b011;
    tick(SETTLE);
    chk("R11 re-armed", {hs_gate, ls_gate}, 6'b100_000);
    idle_all();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule